// File: doc/BRIEF.md
# Lower-Half and Full-Array Write Guard for a Serial Configuration Memory

This block sits beside the byte engine of a two-wire serial memory holding 256 bytes. It has two write-guard flags. The sticky flag, once set, stays set. The removable flag can be set and cleared. Either flag guards the lower half of the array, addresses 0x00 to 0x7F. A write-protect pin guards the whole array, whatever state the flags are in.

For every byte the engine completes, the engine presents the following on the block's inputs:
- the header byte of the transaction;
- which byte of the transaction has just arrived;
- the current word address.

The block answers at once with an acknowledge decision. For data bytes of array writes it also gives a write-commit enable. Header bytes whose upper nibble is 0110 are guard commands. The block decodes these commands itself and changes a flag only when the stop condition arrives.

A qualifier input, `a0_hv`, stands for an elevated level on the lowest strap pin. The removable-flag commands need this level. The flags are meant to survive power loss, so the functional reset does not touch them. A separate initialization strobe presets both flags.

Top module: `spd_wprot_ctrl`

## Requirements
- R1: A header whose upper nibble is 1010 and whose bits [3:1] equal `strap_pins` is acknowledged. This holds for reads and writes, whatever the flags and `wp_pin` are.
- R2: The word-address byte (`phase`=1) is acknowledged after any acknowledged write header, including guard commands.
- R3: An array-write data byte (`phase`=2) is acknowledged and committed when its address is unguarded. With either flag set, addresses 0x00–0x7F are refused (no ack, no commit) and addresses 0x80–0xFF are still written.
- R4: With `wp_pin` high, no array data byte is acknowledged or committed, at any address.
- R5: Header 0110 with bits [3:1]=`strap_pins`, R/W=0 and `a0_hv` low sets the sticky flag at the next stop, after its data byte is acknowledged. Only `init_en` can clear it afterwards.
- R6: While the sticky flag is set, no header with upper nibble 0110 is acknowledged.
- R7: Header 0110 with bits [3:1]=`strap_pins`, R/W=1 and `a0_hv` low is acknowledged only while the sticky flag is clear.
- R8: Header 0x62 with `a0_hv` high and `strap_pins[2:1]`=00 is acknowledged only while the removable flag is clear. The removable flag sets at the stop.
- R9: Header 0x66 with `a0_hv` high, `strap_pins[2]`=0 and `strap_pins[1]`=1 is acknowledged. The removable flag clears at the stop.
- R10: Header 0x63 with `a0_hv` high and `strap_pins[2:1]`=00 is acknowledged only while the removable flag is set.
- R11: With `wp_pin` high, a guard set or clear command still has its header acknowledged. Its data byte is not acknowledged, and neither flag changes.
- R12: `wcyc_o` pulses for one cycle after each stop that ends a transaction with an acknowledged write header. This includes writes that guarding refused. Reads do not produce the pulse.
- R13: `init_en` loads both flags from `init_perm` and `init_rev`. `rst_n` leaves both flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low; flags unaffected |
| init_en | input | 1 | Power-on preset strobe for both flags |
| init_perm | input | 1 | Preset value of the sticky flag |
| init_rev | input | 1 | Preset value of the removable flag |
| hdr_byte | input | 8 | Header byte of the current transaction |
| phase | input | 2 | Byte just received: 0 header, 1 word address, 2 data |
| byte_valid | input | 1 | A byte has completed this cycle |
| word_addr | input | AW | Target word address of the data byte |
| strap_pins | input | 3 | Strap pin levels, bit 2 highest |
| wp_pin | input | 1 | Hardware write-protect pin |
| a0_hv | input | 1 | Elevated-level qualifier on the lowest strap pin |
| stop_det | input | 1 | Stop condition seen this cycle |
| ack_o | output | 1 | Acknowledge the byte now completing |
| commit_o | output | 1 | Write this data byte into the array |
| wcyc_o | output | 1 | One-cycle start of the timed write cycle |

## Verification
The embedded properties watch several rules on every cycle:
- commits never pass a high write-protect pin;
- no lower-half address is committed while a flag is set;
- every 0110 header is refused once the sticky flag is set;
- the sticky flag never drops without the preset strobe;
- a matching array header is always acknowledged;
- the write-cycle pulse only follows a stop.

Some behaviours span whole transactions, and only the bench scenarios show them:
- the opposite polarities of the two status reads;
- the removable flag being set, refused a second time and cleared;
- guard commands under a high protect pin leaving the flags unchanged;
- the flags surviving a functional reset.

// File: rtl/spd_wprot_ctrl.sv
module spd_wprot_ctrl #(
  parameter int          AW        = 8,
  parameter logic [3:0]  MEM_CODE  = 4'hA,
  parameter logic [3:0]  PROT_CODE = 4'h6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_en,
  input  logic          init_perm,
  input  logic          init_rev,
  input  logic [7:0]    hdr_byte,
  input  logic [1:0]    phase,
  input  logic          byte_valid,
  input  logic [AW-1:0] word_addr,
  input  logic [2:0]    strap_pins,
  input  logic          wp_pin,
  input  logic          a0_hv,
  input  logic          stop_det,
  output logic          ack_o,
  output logic          commit_o,
  output logic          wcyc_o
);

  typedef enum logic [2:0] {C_NONE, C_MRD, C_MWR, C_SETP, C_SETR, C_CLRR} cls_t;

  logic perm_q, rev_q, pend_q;
  cls_t cls_q, hdr_cls;
  logic hdr_ack, dat_ack, ack_dec;

  wire code_mem  = hdr_byte[7:4] == MEM_CODE;
  wire code_prot = hdr_byte[7:4] == PROT_CODE;
  wire strap_ok  = hdr_byte[3:1] == strap_pins;
  wire rd_bit    = hdr_byte[0];

  wire is_setp = code_prot & ~a0_hv & strap_ok & ~rd_bit;
  wire is_stsp = code_prot & ~a0_hv & strap_ok &  rd_bit;
  wire is_setr = code_prot & a0_hv & (hdr_byte[3:0] == 4'b0010) & (strap_pins[2:1] == 2'b00);
  wire is_stsr = code_prot & a0_hv & (hdr_byte[3:0] == 4'b0011) & (strap_pins[2:1] == 2'b00);
  wire is_clrr = code_prot & a0_hv & (hdr_byte[3:0] == 4'b0110) & (strap_pins[2:1] == 2'b01);

  wire lower       = ~word_addr[AW-1];
  wire mem_blocked = wp_pin | (lower & (perm_q | rev_q));
  wire wr_cls      = (cls_q == C_MWR) | (cls_q == C_SETP) | (cls_q == C_SETR) | (cls_q == C_CLRR);

  always_comb begin
    hdr_cls = C_NONE;
    if (code_mem && strap_ok)   hdr_cls = rd_bit ? C_MRD : C_MWR;
    else if (perm_q)            hdr_cls = C_NONE;
    else if (is_setp)           hdr_cls = C_SETP;
    else if (is_setr && !rev_q) hdr_cls = C_SETR;
    else if (is_clrr)           hdr_cls = C_CLRR;
  end

  assign hdr_ack = (hdr_cls != C_NONE) | (code_prot & ~perm_q & (is_stsp | (is_stsr & rev_q)));

  always_comb begin
    case (cls_q)
      C_MWR:                 dat_ack = ~mem_blocked;
      C_SETP, C_SETR, C_CLRR: dat_ack = ~wp_pin;
      default:               dat_ack = 1'b0;
    endcase
  end

  always_comb begin
    case (phase)
      2'd0:    ack_dec = hdr_ack;
      2'd1:    ack_dec = wr_cls;
      2'd2:    ack_dec = dat_ack;
      default: ack_dec = 1'b0;
    endcase
  end

  assign ack_o    = byte_valid & ack_dec;
  assign commit_o = byte_valid & (phase == 2'd2) & (cls_q == C_MWR) & ~mem_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= C_NONE;
      pend_q <= 1'b0;
      wcyc_o <= 1'b0;
    end else begin
      wcyc_o <= stop_det & wr_cls;
      if (stop_det) begin
        cls_q  <= C_NONE;
        pend_q <= 1'b0;
      end else if (byte_valid && phase == 2'd0) begin
        cls_q  <= hdr_ack ? hdr_cls : C_NONE;
        pend_q <= 1'b0;
      end else if (byte_valid && phase == 2'd2 && dat_ack && cls_q != C_MWR) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (init_en) begin
      perm_q <= init_perm;
      rev_q  <= init_rev;
    end else if (rst_n && stop_det && pend_q) begin
      case (cls_q)
        C_SETP:  perm_q <= 1'b1;
        C_SETR:  rev_q  <= 1'b1;
        C_CLRR:  rev_q  <= 1'b0;
        default: ;
      endcase
    end
  end

  // R1
  mem_hdr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && phase == 2'd0 && hdr_byte[7:4] == MEM_CODE && hdr_byte[3:1] == strap_pins) |-> ack_o);

  // R3
  lower_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && !word_addr[AW-1]) |-> !(perm_q || rev_q));

  // R4
  wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> !commit_o);

  // R5
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_q && !init_en) |=> perm_q);

  // R6
  prot_hdr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_q && byte_valid && phase == 2'd0 && hdr_byte[7:4] == PROT_CODE) |-> !ack_o);

  // R12
  wcyc_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_o |-> $past(stop_det));

endmodule

// File: tb/spd_wprot_ctrl_tb_top.sv
`timescale 1ns/1ps
module spd_wprot_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, init_en = 1'b0, init_perm = 1'b0, init_rev = 1'b0;
  logic [7:0] hdr_byte = 8'h00, word_addr = 8'h00;
  logic [1:0] phase = 2'd0;
  logic byte_valid = 1'b0, wp_pin = 1'b0, a0_hv = 1'b0, stop_det = 1'b0;
  logic [2:0] strap_pins = 3'b101;
  logic ack_o, commit_o, wcyc_o;
  int n_chk = 0, n_err = 0;
  logic a, c, w;

  always #4 clk = ~clk;

  spd_wprot_ctrl dut_i (.clk(clk), .rst_n(rst_n), .init_en(init_en), .init_perm(init_perm),
    .init_rev(init_rev), .hdr_byte(hdr_byte), .phase(phase), .byte_valid(byte_valid),
    .word_addr(word_addr), .strap_pins(strap_pins), .wp_pin(wp_pin), .a0_hv(a0_hv),
    .stop_det(stop_det), .ack_o(ack_o), .commit_o(commit_o), .wcyc_o(wcyc_o));

  // {init_perm, init_rev, wp, addr[7:0], exp data ack, exp commit}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'h10, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h80, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'h7F, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'hC0, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'h90, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic put(input logic [1:0] ph, input logic [7:0] hb, input logic [7:0] ad,
                     output logic ao, output logic co);
    @(negedge clk);
    phase = ph; hdr_byte = hb; word_addr = ad; byte_valid = 1'b1;
    #1; ao = ack_o; co = commit_o;
    @(posedge clk); #1 byte_valid = 1'b0;
  endtask

  task automatic stop_t(output logic wo);
    @(negedge clk); stop_det = 1'b1;
    @(posedge clk); #1 stop_det = 1'b0;
    @(negedge clk); wo = wcyc_o;
  endtask

  task automatic preset(input logic p, input logic r);
    @(negedge clk); init_en = 1'b1; init_perm = p; init_rev = r;
    @(posedge clk); #1 init_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    preset(1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    chk("reset ack R1", ack_o, 1'b0);
    chk("reset commit R3", commit_o, 1'b0);
    chk("reset wcyc R12", wcyc_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [12:0] v;
      v = VEC[i];
      preset(v[12], v[11]);
      wp_pin = v[10];
      put(2'd0, 8'hAA, 8'h00, a, c);   chk("table header R1", a, 1'b1);
      put(2'd1, 8'hAA, v[9:2], a, c);  chk("table address R2", a, 1'b1);
      put(2'd2, 8'hAA, v[9:2], a, c);
      chk("table data ack R3", a, v[1]);
      chk("table commit R4", c, v[0]);
      stop_t(w);                       chk("table write cycle R12", w, 1'b1);
    end

    // reads acked under all guards; no write cycle after a read
    preset(1'b1, 1'b1); wp_pin = 1'b1;
    put(2'd0, 8'hAB, 8'h00, a, c); chk("read header R1", a, 1'b1);
    stop_t(w);                      chk("read no wcyc R12", w, 1'b0);
    put(2'd0, 8'hA2, 8'h00, a, c); chk("strap mismatch R1", a, 1'b0);

    // WP high: guard command refused at data, flags unchanged
    preset(1'b0, 1'b0);
    put(2'd0, 8'h6A, 8'h00, a, c); chk("wp set header R11", a, 1'b1);
    put(2'd1, 8'h6A, 8'h00, a, c); chk("wp set address R2", a, 1'b1);
    put(2'd2, 8'h6A, 8'h00, a, c); chk("wp set data R11", a, 1'b0);
    stop_t(w);                      chk("wp refused wcyc R12", w, 1'b1);
    wp_pin = 1'b0;
    put(2'd0, 8'h6B, 8'h00, a, c); chk("sticky still clear R11", a, 1'b1);
    stop_t(w);

    // removable flag
    strap_pins = 3'b000; a0_hv = 1'b1;
    put(2'd0, 8'h63, 8'h00, a, c); chk("rev status clear R10", a, 1'b0);
    put(2'd0, 8'h62, 8'h00, a, c); chk("rev set header R8", a, 1'b1);
    put(2'd1, 8'h62, 8'h00, a, c); chk("rev set address R2", a, 1'b1);
    put(2'd2, 8'h62, 8'h00, a, c); chk("rev set data R8", a, 1'b1);
    stop_t(w);
    put(2'd0, 8'h63, 8'h00, a, c); chk("rev status set R10", a, 1'b1);
    stop_t(w);
    put(2'd0, 8'h62, 8'h00, a, c); chk("rev set again R8", a, 1'b0);
    stop_t(w);
    a0_hv = 1'b0;
    put(2'd0, 8'hA0, 8'h00, a, c);
    put(2'd1, 8'hA0, 8'h20, a, c);
    put(2'd2, 8'hA0, 8'h20, a, c); chk("rev guards lower R3", c, 1'b0);
    stop_t(w);
    strap_pins = 3'b010; a0_hv = 1'b1;
    put(2'd0, 8'h66, 8'h00, a, c); chk("rev clear header R9", a, 1'b1);
    put(2'd1, 8'h66, 8'h00, a, c);
    put(2'd2, 8'h66, 8'h00, a, c); chk("rev clear data R9", a, 1'b1);
    stop_t(w);
    strap_pins = 3'b000;
    put(2'd0, 8'h63, 8'h00, a, c); chk("rev cleared status R9", a, 1'b0);
    a0_hv = 1'b0;
    put(2'd0, 8'hA0, 8'h00, a, c);
    put(2'd1, 8'hA0, 8'h20, a, c);
    put(2'd2, 8'hA0, 8'h20, a, c); chk("lower writable again R9", c, 1'b1);
    stop_t(w);

    // sticky flag
    strap_pins = 3'b101;
    put(2'd0, 8'h6B, 8'h00, a, c); chk("sticky status clear R7", a, 1'b1);
    stop_t(w);
    put(2'd0, 8'h6A, 8'h00, a, c); chk("sticky set header R5", a, 1'b1);
    put(2'd1, 8'h6A, 8'h33, a, c);
    put(2'd2, 8'h6A, 8'h5C, a, c); chk("sticky set data R5", a, 1'b1);
    stop_t(w);                      chk("sticky set wcyc R12", w, 1'b1);
    put(2'd0, 8'h6B, 8'h00, a, c); chk("sticky status set R7", a, 1'b0);
    put(2'd0, 8'h6A, 8'h00, a, c); chk("sticky set refused R6", a, 1'b0);
    strap_pins = 3'b010; a0_hv = 1'b1;
    put(2'd0, 8'h66, 8'h00, a, c); chk("rev clear refused R6", a, 1'b0);
    strap_pins = 3'b101; a0_hv = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    put(2'd0, 8'h6B, 8'h00, a, c); chk("sticky survives reset R13", a, 1'b0);
    put(2'd0, 8'hAA, 8'h00, a, c);
    put(2'd1, 8'hAA, 8'h10, a, c);
    put(2'd2, 8'hAA, 8'h10, a, c); chk("sticky guards lower R5", a, 1'b0);
    stop_t(w);
    preset(1'b0, 1'b0);
    put(2'd0, 8'h6B, 8'h00, a, c); chk("preset clears sticky R13", a, 1'b1);
    stop_t(w);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule